// File: doc/BRIEF.md
# Calendar Clock Register File with BCD Carry

This block keeps wall-clock time and date in a small byte-addressed register bank and advances it once per pulse on a one-second tick input. Seconds, minutes, hours, day of week, day of month, month and a two-digit year sit in the low addresses. Above them are four control and status bytes. A host reads and writes all of them over a simple synchronous bus with an 8-bit address and 8-bit data. Reads return their byte one cycle after the request.

The date advances with a full calendar carry chain. The fields are kept in either packed BCD or plain binary, chosen by a data-mode bit in the second control byte. The year is stored modulo 100 and is read as 1950–2049, so leap years follow year % 4 == 0. A SET bit freezes time while software loads it. The update-in-progress flag is read-only and flips on every read, so a polling loop always sees it change.

Alarm, update-ended interrupts, 12-hour display and daylight-saving correction are not implemented. Enabling any of them raises a one-cycle warning pulse.

Top module: `rtc_calendar_regs`

## Requirements
- R1: After reset every byte at 0x00–0x09 reads 0x00. Register B (0x0B) reads 0x42 in BCD build (bit 6 periodic enable, bit 1 24-hour, bit 2 data mode from the BIN_MODE parameter). Register A (0x0A) holds 0x26, with divider code 3'b010 in bits 6:4 and rate code 4'b0110 in bits 3:0.
- R2: A read with `rd_en` high presents its byte on `rdata` in the following cycle. Addresses 0x0E and above read 0x00.
- R3: A write to 0x00–0x09 loads that byte directly. The time fields are at 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week, 0x07 day of month, 0x08 month and 0x09 year. Bytes 0x01, 0x03 and 0x05 are plain storage and never change on a tick.
- R4: With B bit 2 clear, each accepted tick advances the fields in packed BCD (tens in bits 7:4, units in bits 3:0). Seconds 59→00 carries into minutes, minutes 59→00 into hours, and hours 23→00 into the day.
- R5: With B bit 2 set, the same carry chain runs on plain binary values.
- R6: Day of month wraps to 1 after 30 for months 4, 6, 9 and 11, and after 31 for the other months. For month 2 it wraps after 29 when year % 4 == 0 and after 28 otherwise; this includes year 00.
- R7: A month wrap of 12→1 increments the year, and year 99 wraps to 00.
- R8: Day of week advances on every day carry and wraps from 7 to 1, where 1 is Sunday.
- R9: Bit 7 of register A (update in progress) is read-only. A write to A changes only bits 6:0.
- R10: Each read of register A inverts bit 7 and then returns the byte with the inverted value.
- R11: While B bit 7 (SET) is 1, ticks leave all time bytes unchanged.
- R12: Registers C (0x0C) and D (0x0D) always read 0x00, and writes to them are ignored.
- R13: `unsupported` pulses high for one cycle, in the cycle after a write to B that sets bit 5, bit 4 or bit 0, or clears bit 1. A write to B without any of these leaves it low.
- R14: A tick in the same cycle as a write to 0x00–0x09 is discarded. Only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sec | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| unsupported | output | 1 | One-cycle pulse on an unsupported configuration write |

## Verification
The tick and a bus write to a time byte can land on the same clock edge. The design then keeps the written byte and drops the advance, so no neighbouring field carries. The bench drives a tick alongside a seconds write while the seconds and minutes sit at 59. It expects the written seconds value and unchanged minutes, not a carried result. A read of register A can also coincide with a write to A. In that case the read-triggered flip of the update flag wins, and the random phase compares every read against a bench model that applies the same rule.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int TIME_BYTES = 10;
  localparam int TIME_AW    = $clog2(TIME_BYTES);

  // field addresses, decoded by host software
  localparam logic [7:0] ADR_SEC = 8'h00;
  localparam logic [7:0] ADR_MIN = 8'h02;
  localparam logic [7:0] ADR_HR  = 8'h04;
  localparam logic [7:0] ADR_DOW = 8'h06;
  localparam logic [7:0] ADR_DOM = 8'h07;
  localparam logic [7:0] ADR_MON = 8'h08;
  localparam logic [7:0] ADR_YR  = 8'h09;
  localparam logic [7:0] ADR_A   = 8'h0A;
  localparam logic [7:0] ADR_B   = 8'h0B;
  localparam logic [7:0] ADR_C   = 8'h0C;
  localparam logic [7:0] ADR_D   = 8'h0D;

  // register B bit positions
  localparam int B_SET = 7;
  localparam int B_PIE = 6;
  localparam int B_AIE = 5;
  localparam int B_UIE = 4;
  localparam int B_DM  = 2;
  localparam int B_24H = 1;
  localparam int B_DSE = 0;

  localparam logic [2:0] DIV_32K  = 3'b010;
  localparam logic [3:0] RATE_1K  = 4'b0110;

  // stored byte -> numeric value
  function automatic logic [6:0] fld_dec(input logic [7:0] b, input logic bin);
    if (bin) return b[6:0];
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  // numeric value -> stored byte
  function automatic logic [7:0] fld_enc(input logic [6:0] v, input logic bin);
    if (bin) return {1'b0, v};
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  // last day of a month, year is two-digit in the 1950-2049 window
  function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 return 7'd31;
    endcase
  endfunction

  // step a field that wraps to lo after reaching hi
  function automatic logic [6:0] wrap_inc(input logic [6:0] v, input logic [6:0] hi,
                                          input logic [6:0] lo);
    return (v >= hi) ? lo : v + 7'd1;
  endfunction

endpackage

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
#(
  parameter int NBYTES = TIME_BYTES,
  localparam int AW = $clog2(NBYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   bin_i,
  input  logic                   set_i,
  input  logic                   wr_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [7:0]             wdata_i,
  output logic [NBYTES-1:0][7:0] time_o
);

  logic [NBYTES-1:0][7:0] time_q;
  logic [NBYTES-1:0][7:0] adv_val;

  // decoded fields
  logic [6:0] sec_v, min_v, hr_v, dow_v, dom_v, mon_v, yr_v, mlen;
  // carry chain events, named for the assertions
  logic cy_min, cy_hr, cy_day, cy_mon, cy_yr;
  logic advance;

  assign sec_v = fld_dec(time_q[ADR_SEC[AW-1:0]], bin_i);
  assign min_v = fld_dec(time_q[ADR_MIN[AW-1:0]], bin_i);
  assign hr_v  = fld_dec(time_q[ADR_HR[AW-1:0]],  bin_i);
  assign dow_v = fld_dec(time_q[ADR_DOW[AW-1:0]], bin_i);
  assign dom_v = fld_dec(time_q[ADR_DOM[AW-1:0]], bin_i);
  assign mon_v = fld_dec(time_q[ADR_MON[AW-1:0]], bin_i);
  assign yr_v  = fld_dec(time_q[ADR_YR[AW-1:0]],  bin_i);
  assign mlen  = month_len(mon_v, yr_v);

  assign cy_min = (sec_v >= 7'd59);
  assign cy_hr  = cy_min && (min_v >= 7'd59);
  assign cy_day = cy_hr  && (hr_v  >= 7'd23);
  assign cy_mon = cy_day && (dom_v >= mlen);
  assign cy_yr  = cy_mon && (mon_v >= 7'd12);

  // write has priority: a coinciding tick is dropped
  assign advance = tick_i && !set_i && !wr_i;

  always_comb begin
    adv_val = time_q;
    adv_val[ADR_SEC[AW-1:0]] = fld_enc(wrap_inc(sec_v, 7'd59, 7'd0), bin_i);
    if (cy_min) adv_val[ADR_MIN[AW-1:0]] = fld_enc(wrap_inc(min_v, 7'd59, 7'd0), bin_i);
    if (cy_hr)  adv_val[ADR_HR[AW-1:0]]  = fld_enc(wrap_inc(hr_v, 7'd23, 7'd0), bin_i);
    if (cy_day) begin
      adv_val[ADR_DOW[AW-1:0]] = fld_enc(wrap_inc(dow_v, 7'd7, 7'd1), bin_i);
      adv_val[ADR_DOM[AW-1:0]] = fld_enc(wrap_inc(dom_v, mlen, 7'd1), bin_i);
    end
    if (cy_mon) adv_val[ADR_MON[AW-1:0]] = fld_enc(wrap_inc(mon_v, 7'd12, 7'd1), bin_i);
    if (cy_yr)  adv_val[ADR_YR[AW-1:0]]  = fld_enc(wrap_inc(yr_v, 7'd99, 7'd0), bin_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
    end else begin
      for (int i = 0; i < NBYTES; i++) begin
        if (wr_i && (waddr_i == AW'(i)))
          time_q[i] <= wdata_i;
        else if (advance)
          time_q[i] <= adv_val[i];
      end
    end
  end

  assign time_o = time_q;

  assert_set_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && set_i && !wr_i) |=> $stable(time_q));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sec_v == 7'd59) |=> (sec_v == 7'd0));

  assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cy_day && dow_v == 7'd7) |=> (dow_v == 7'd1));

  assert_year_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cy_yr && yr_v == 7'd99) |=> (yr_v == 7'd0));

  assert_tick_drop_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && wr_i) |=> (time_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter bit BIN_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       rd_a_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] a_rd_val_o,
  output logic [7:0] reg_b_o,
  output logic       unsup_o
);

  localparam logic [7:0] B_RESET = 8'((1 << B_PIE) | (1 << B_24H) | (int'(BIN_MODE) << B_DM));

  logic       uip_q;
  logic [6:0] a_low_q;
  logic [7:0] b_q;
  logic       bad_cfg;
  logic       unsup_q;

  assign bad_cfg = wdata_i[B_AIE] || wdata_i[B_UIE] || wdata_i[B_DSE] || !wdata_i[B_24H];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q   <= 1'b0;
      a_low_q <= {DIV_32K, RATE_1K};
      b_q     <= B_RESET;
      unsup_q <= 1'b0;
    end else begin
      if (wr_a_i) a_low_q <= wdata_i[6:0];
      if (rd_a_i) uip_q   <= !uip_q;
      if (wr_b_i) b_q     <= wdata_i;
      unsup_q <= wr_b_i && bad_cfg;
    end
  end

  // read of A returns the already inverted flag
  assign a_rd_val_o = {!uip_q, a_low_q};
  assign reg_b_o    = b_q;
  assign unsup_o    = unsup_q;

  assert_uip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_i && !rd_a_i) |=> (uip_q == $past(uip_q)));

  assert_uip_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_i |=> (uip_q != $past(uip_q)));

  assert_unsup_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b_i && bad_cfg) |=> unsup_o);

  assert_unsup_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_b_i && bad_cfg) |=> !unsup_o);

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_cal_pkg::*;
#(
  parameter bit BIN_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_sec,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       unsupported
);

  localparam int NB = TIME_BYTES;
  localparam int AW = TIME_AW;

  logic [NB-1:0][7:0] time_bytes;
  logic [7:0]         a_rd_val, reg_b;
  logic               time_hit, wr_time, wr_a, wr_b, rd_a;
  logic [7:0]         rd_next;

  assign time_hit = (addr < 8'(NB));
  assign wr_time  = wr_en && time_hit;
  assign wr_a     = wr_en && (addr == ADR_A);
  assign wr_b     = wr_en && (addr == ADR_B);
  assign rd_a     = rd_en && (addr == ADR_A);

  rtc_cal_core #(.NBYTES(NB)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_sec),
    .bin_i   (reg_b[B_DM]),
    .set_i   (reg_b[B_SET]),
    .wr_i    (wr_time),
    .waddr_i (addr[AW-1:0]),
    .wdata_i (wdata),
    .time_o  (time_bytes)
  );

  rtc_cal_ctrl #(.BIN_MODE(BIN_MODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_a_i     (wr_a),
    .wr_b_i     (wr_b),
    .rd_a_i     (rd_a),
    .wdata_i    (wdata),
    .a_rd_val_o (a_rd_val),
    .reg_b_o    (reg_b),
    .unsup_o    (unsupported)
  );

  always_comb begin
    rd_next = 8'h00;
    if (time_hit) begin
      for (int i = 0; i < NB; i++)
        if (addr[AW-1:0] == AW'(i)) rd_next = time_bytes[i];
    end else if (addr == ADR_A) begin
      rd_next = a_rd_val;
    end else if (addr == ADR_B) begin
      rd_next = reg_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= rd_next;
  end

  assert_cd_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == ADR_C || addr == ADR_D)) |=> (rdata == 8'h00));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/rtc_calendar_regs_tb.sv
`timescale 1ns/1ps
module rtc_calendar_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_sec = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_t [10];
  logic [7:0] m_b;
  logic [6:0] m_a;
  logic       m_uip;

  always #4 clk = ~clk;

  rtc_calendar_regs u_dut (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .unsupported(unsupported));

  function automatic int to_num(input logic [7:0] b, input bit bin);
    int tens = b >> 4;
    return bin ? int'(b) : tens * 10 + int'(b & 8'h0F);
  endfunction

  function automatic logic [7:0] to_byte(input int v, input bit bin);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int days_of(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    bit bin = m_b[2];
    int s, mi, h, w, d, mo, y;
    if (m_b[7]) return;
    s = to_num(m_t[0], bin); mi = to_num(m_t[2], bin); h = to_num(m_t[4], bin);
    w = to_num(m_t[6], bin); d = to_num(m_t[7], bin); mo = to_num(m_t[8], bin);
    y = to_num(m_t[9], bin);
    s++;
    if (s == 60) begin s = 0; mi++; end
    if (mi == 60) begin mi = 0; h++; end
    if (h == 24) begin
      h = 0; d++; w = (w == 7) ? 1 : w + 1;
      if (d > days_of(mo, y)) begin d = 1; mo++; end
      if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
    end
    m_t[0] = to_byte(s, bin); m_t[2] = to_byte(mi, bin); m_t[4] = to_byte(h, bin);
    m_t[6] = to_byte(w, bin); m_t[7] = to_byte(d, bin); m_t[8] = to_byte(mo, bin);
    m_t[9] = to_byte(y, bin);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a < 8'd10) m_t[a] = d;
    else if (a == 8'h0A) m_a = d[6:0];
    else if (a == 8'h0B) m_b = d;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; tick_sec = with_tick;
    @(negedge clk);
    wr_en = 0; tick_sec = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    v = rdata;
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a < 8'd10) return m_t[a];
    if (a == 8'h0A) begin m_uip = ~m_uip; return {m_uip, m_a}; end
    if (a == 8'h0B) return m_b;
    return 8'h00;
  endfunction

  task automatic read_model(input logic [7:0] a, input string tag);
    logic [7:0] v;
    bus_read(a, v);
    check(tag, v, model_read(a));
  endtask

  task automatic read_lit(input logic [7:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    bus_read(a, v);
    if (a == 8'h0A) m_uip = ~m_uip;
    check(tag, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_sec = 1;
      @(negedge clk); tick_sec = 0;
      model_tick();
    end
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
    bus_write(8'h00, s); bus_write(8'h02, mi); bus_write(8'h04, h); bus_write(8'h06, w);
    bus_write(8'h07, d); bus_write(8'h08, mo); bus_write(8'h09, y);
  endtask

  task automatic unsup_case(input logic [7:0] bval, input logic exp, input string tag);
    @(negedge clk);
    wr_en = 1; addr = 8'h0B; wdata = bval;
    @(negedge clk);
    wr_en = 0;
    model_write(8'h0B, bval);
    check(tag, {7'd0, unsupported}, {7'd0, exp});
    @(negedge clk);
    check({tag, " pulse ends"}, {7'd0, unsupported}, 8'h00);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 10; i++) m_t[i] = 8'h00;
    m_b = 8'h42; m_a = 7'h26; m_uip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    read_lit(8'h00, 8'h00, "R1 sec reset");
    read_lit(8'h09, 8'h00, "R1 year reset");
    read_lit(8'h0B, 8'h42, "R1 regB reset");
    read_lit(8'h0A, 8'hA6, "R1 R10 regA first read");
    read_lit(8'h0A, 8'h26, "R10 regA second read");
    // R2 unmapped
    read_lit(8'h0E, 8'h00, "R2 unmapped 0x0E");
    read_lit(8'hFF, 8'h00, "R2 unmapped 0xFF");

    // R3 storage bytes and direct load
    bus_write(8'h01, 8'h5A); bus_write(8'h03, 8'hC3);
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    read_lit(8'h07, 8'h31, "R3 day load");
    ticks(1);
    // R4 R7 R8 full rollover
    read_lit(8'h00, 8'h00, "R4 sec wrap");
    read_lit(8'h02, 8'h00, "R4 min wrap");
    read_lit(8'h04, 8'h00, "R4 hour wrap");
    read_lit(8'h06, 8'h01, "R8 dow 7->1");
    read_lit(8'h07, 8'h01, "R6 dec31 -> 1");
    read_lit(8'h08, 8'h01, "R7 month 12->1");
    read_lit(8'h09, 8'h00, "R7 year 99->00");
    read_lit(8'h01, 8'h5A, "R3 storage 0x01 kept");
    read_lit(8'h03, 8'hC3, "R3 storage 0x03 kept");

    // R6 leap rules
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    ticks(1);
    read_lit(8'h07, 8'h29, "R6 feb28 leap 24");
    read_lit(8'h06, 8'h03, "R8 dow step");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    ticks(1);
    read_lit(8'h08, 8'h03, "R6 feb29 -> mar");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    ticks(1);
    read_lit(8'h07, 8'h01, "R6 feb28 non-leap");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    ticks(1);
    read_lit(8'h07, 8'h29, "R6 year 00 leap");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h10);
    ticks(1);
    read_lit(8'h08, 8'h05, "R6 apr30 -> may");
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h10);
    ticks(1);
    read_lit(8'h07, 8'h31, "R6 may30 -> 31");

    // R5 binary mode
    bus_write(8'h0B, 8'h46);
    load_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1E, 8'h04, 8'h17);
    ticks(1);
    read_lit(8'h00, 8'h00, "R5 bin sec");
    read_lit(8'h04, 8'h00, "R5 bin hour");
    read_lit(8'h07, 8'h01, "R5 bin day");
    read_lit(8'h08, 8'h05, "R5 bin month");
    ticks(10);
    read_lit(8'h00, 8'h0A, "R5 bin sec 10");
    bus_write(8'h0B, 8'h42);

    // R11 SET freeze
    load_time(8'h10, 8'h20, 8'h05, 8'h01, 8'h05, 8'h06, 8'h30);
    bus_write(8'h0B, 8'hC2);
    ticks(5);
    read_lit(8'h00, 8'h10, "R11 frozen sec");
    bus_write(8'h0B, 8'h42);
    ticks(1);
    read_lit(8'h00, 8'h11, "R11 resumes");

    // R9 UIP write protection (model uip now 0)
    bus_write(8'h0A, 8'hFF);
    read_lit(8'h0A, 8'hFF, "R9 uip after write");
    bus_write(8'h0A, 8'h26);
    read_lit(8'h0A, 8'h26, "R9 R10 uip toggles back");

    // R12 C/D
    bus_write(8'h0C, 8'hFF); bus_write(8'h0D, 8'h77);
    read_lit(8'h0C, 8'h00, "R12 regC");
    read_lit(8'h0D, 8'h00, "R12 regD");

    // R13 unsupported
    unsup_case(8'h62, 1'b1, "R13 alarm enable");
    unsup_case(8'h52, 1'b1, "R13 update enable");
    unsup_case(8'h43, 1'b1, "R13 dst enable");
    unsup_case(8'h40, 1'b1, "R13 12h mode");
    unsup_case(8'h42, 1'b0, "R13 clean write");

    // R14 tick colliding with write
    load_time(8'h59, 8'h59, 8'h10, 8'h01, 8'h05, 8'h06, 8'h30);
    bus_write(8'h00, 8'h30, 1'b1);
    read_lit(8'h00, 8'h30, "R14 write wins");
    read_lit(8'h02, 8'h59, "R14 no carry");

    // random phase, BCD mode, model-compared
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        int f = $urandom_range(0, 9);
        int v;
        case (f)
          0, 2:    v = $urandom_range(0, 59);
          4:       v = $urandom_range(0, 23);
          6:       v = $urandom_range(1, 7);
          7:       v = $urandom_range(1, 28);
          8:       v = $urandom_range(1, 12);
          9:       v = $urandom_range(0, 99);
          default: v = $urandom_range(0, 255);
        endcase
        bus_write(8'(f), (f == 1 || f == 3 || f == 5) ? 8'(v) : to_byte(v, 0));
      end else if (op < 6) begin
        ticks($urandom_range(1, 70));
      end else if (op == 6) begin
        bus_write(8'h0B, ($urandom_range(0, 3) == 0) ? 8'hC2 : 8'h42);
      end else begin
        read_model(8'($urandom_range(0, 15)), "R2 R3 R4 random read");
      end
    end
    for (int a = 0; a < 14; a++) read_model(8'(a), "R4 R10 final sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule